// File: doc/BRIEF.md
# Priority Interrupt Controller with Polled Acknowledge

This block arbitrates interrupt requests from timer and external lines for a small 16-bit processor. Every request slot holds a latched pending bit, an in-service bit and a control word that carries a mask bit and a 3-bit priority. The controller asks the core for service whenever a slot is eligible. A slot is eligible when it is pending, not masked, and outranks every slot already in service.

Software reaches the block through a one-cycle synchronous register bus. Two read-only words report the winning slot. Reading one of them acknowledges the winner. Reading the other only observes it and changes nothing. An end-of-service write retires a slot in one of two ways: by naming its vector, or by retiring whichever in-service slot ranks highest.

A configuration bit switches the controller from stand-alone operation to subordinate operation. In subordinate mode, each timer becomes its own slot, the external lines are shut out, and the request goes to an upstream controller instead of the core.

Top module: `prio_pic`

## Requirements
- R1: After reset, configuration reads 0x0000. Every control word reads 0x000F (bit 3 is the mask, set; bits 2:0 are the priority, 7). The in-service word (address 5) and the pending word (address 6) read 0. Both request outputs are low.
- R2: The status word (address 4) and the acknowledge word (address 3) share one layout. Bit 15 is 1 when an eligible slot exists. Bits 4:0 hold that slot's vector, which is 8 plus the slot index. All other bits are 0. When no slot is eligible, the whole word is 0x0000.
- R3: A read of the status word changes neither the in-service bits nor the pending bits. Repeated reads return the same value.
- R4: A read of the acknowledge word returns the winning word, sets the winner's in-service bit and clears its pending bit, exactly once per read strobe. When no slot is eligible, the read returns 0x0000 and changes nothing.
- R5: The lower 3-bit priority value wins. When two slots have equal values, the lower slot index wins.
- R6: A pending slot is eligible only when its priority value is strictly lower than that of every in-service slot.
- R7: A masked slot still latches pending, but it is not eligible. It becomes eligible once its mask bit is cleared.
- R8: End-of-service writes go to address 2. With bit 15 = 0, the write clears the in-service bit of the slot whose vector is in bits 4:0. With bit 15 = 1, it clears the in-service bit of the highest-ranked in-service slot.
- R9: In stand-alone mode (configuration bit 14 = 0), slot 0 is raised by any timer line. External lines 0 and 1 feed slots 3 and 4. Slots 1 and 2 never become pending.
- R10: Writing configuration bit 14 = 1 selects subordinate mode. In this mode, timer i feeds slot i, and the external lines never make a slot pending.
- R11: `cpu_irq` is high exactly when an eligible slot exists in stand-alone mode. `up_req` is high exactly when an eligible slot exists in subordinate mode. Each output falls in the cycle the acknowledged slot's in-service bit is set.
- R12: A one-cycle `int_ack` pulse acknowledges the winner in the same way as an acknowledge-word read.
- R13: A slot becomes pending on a rising edge of its request line. A line that stays high does not make the slot pending again after it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one per cycle held |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after the strobe |
| tmr_req | input | NUM_TMR | Timer request lines |
| ext_req | input | NUM_EXT | External request lines |
| int_ack | input | 1 | Hardware acknowledge strobe |
| cpu_irq | output | 1 | Request to the core (stand-alone mode) |
| up_req | output | 1 | Request to the upstream controller (subordinate mode) |

## Verification
Arbitration is tested with several patterns. Single pending slots check the vector encoding. Pairs with different priorities check the value comparison, and pairs with equal priorities show that the index tie-break decides. Nested cases follow an acknowledge with a lower-ranked request, then with an equal-ranked request. These show that eligibility needs a strictly higher rank, and not merely an unmasked pending bit. Status reads interleaved with in-service and pending readbacks separate the peek path from the acknowledge path. Held and pulsed request lines separate edge capture from level capture. Repeating the timer and external stimulus in each mode shows how each mode maps lines to slots.

// File: rtl/prio_pic_pkg.sv
// Shared constants and helpers for the priority interrupt controller.
// Assumes a 16-bit register bus with 4-bit word addresses.
package prio_pic_pkg;
    localparam int DATA_W    = 16;
    localparam int PRIO_W    = 3;
    localparam int VEC_W     = 5;
    localparam int CTRL_W    = 4;      // {mask, prio[2:0]}
    localparam int SLAVE_BIT = 14;     // configuration: subordinate mode
    localparam int NSPEC_BIT = 15;     // end-of-service: by rank
    localparam int REQ_BIT   = 15;     // poll words: request present

    typedef enum logic [3:0] {
        A_CFG   = 4'd0,
        A_EOI   = 4'd2,
        A_POLL  = 4'd3,
        A_PSTAT = 4'd4,
        A_INSVC = 4'd5,
        A_PEND  = 4'd6
    } addr_e;

    localparam logic [3:0] A_CTRL0 = 4'd8;

    // Build a poll-layout word from a found flag and a vector.
    function automatic logic [DATA_W-1:0] poll_word(input logic found,
                                                     input logic [VEC_W-1:0] vec);
        logic [DATA_W-1:0] w;
        w = '0;
        if (found) begin
            w[REQ_BIT]     = 1'b1;
            w[VEC_W-1:0]   = vec;
        end
        return w;
    endfunction
endpackage

// File: rtl/pic_src_map.sv
// Maps raw timer and external lines onto arbitration slots by mode.
// Slots 0..NUM_TMR-1 are timer slots, the rest are external slots.
// Assumes inputs are already synchronous to clk.
module pic_src_map #(
    parameter int NUM_TMR = 3,
    parameter int NUM_EXT = 2,
    localparam int NSRC   = NUM_TMR + NUM_EXT
) (
    input  logic               slave,
    input  logic [NUM_TMR-1:0] tmr_req,
    input  logic [NUM_EXT-1:0] ext_req,
    output logic [NSRC-1:0]    slot_req,
    output logic [NSRC-1:0]    slot_act
);
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        if (t == 0) begin : g_shared
            // Slot 0: all timers merged in stand-alone mode, timer 0 alone otherwise
            assign slot_req[0] = slave ? tmr_req[0] : |tmr_req;
            assign slot_act[0] = 1'b1;
        end else begin : g_own
            // Remaining timer slots exist only in subordinate mode
            assign slot_req[t] = slave & tmr_req[t];
            assign slot_act[t] = slave;
        end
    end

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        // External slots are cut off in subordinate mode
        assign slot_req[NUM_TMR+e] = ~slave & ext_req[e];
        assign slot_act[NUM_TMR+e] = ~slave;
    end
endmodule

// File: rtl/pic_arbiter.sv
// Picks the requesting slot with the lowest priority value; ties go to
// the lowest index. Purely combinational.
module pic_arbiter
    import prio_pic_pkg::*;
#(
    parameter int N       = 5,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        req,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                found,
    output logic [IDX_W-1:0]    idx,
    output logic [PRIO_W-1:0]   best
);
    // Linear scan; strict compare keeps the earlier index on a tie
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            logic [PRIO_W-1:0] p;
            p = prio_flat[i*PRIO_W +: PRIO_W];
            if (req[i] && (!found || p < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = p;
            end
        end
    end
endmodule

// File: rtl/prio_pic.sv
// Priority interrupt controller with acknowledge and peek poll words,
// specific and ranked end-of-service, and a subordinate mode.
// Assumes NUM_TMR + NUM_EXT <= 8 (control words at addresses 8..15)
// and VEC_BASE + slots fits in 5 bits.
module prio_pic
    import prio_pic_pkg::*;
#(
    parameter int NUM_TMR  = 3,
    parameter int NUM_EXT  = 2,
    parameter int VEC_BASE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [3:0]         bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic [NUM_TMR-1:0] tmr_req,
    input  logic [NUM_EXT-1:0] ext_req,
    input  logic               int_ack,
    output logic               cpu_irq,
    output logic               up_req
);
    localparam int NSRC  = NUM_TMR + NUM_EXT;
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic                   slave_q;
    logic [NSRC*CTRL_W-1:0] ctrl_q;
    logic [NSRC-1:0]        pend_q, insvc_q, req_q;
    logic [DATA_W-1:0]      rdata_q;

    logic [NSRC-1:0]        slot_req, slot_act, req_rise;
    logic [NSRC-1:0]        mask;
    logic [NSRC*PRIO_W-1:0] prio_flat;
    logic [NSRC-1:0]        elig, ack_set, eoi_clr;

    logic                   is_found, pd_found;
    logic [IDX_W-1:0]       is_idx, pd_idx;
    logic [PRIO_W-1:0]      is_best, pd_best;

    logic                   ack_req, ack_fire, eoi_wr, eoi_nspec;
    logic [VEC_W-1:0]       eoi_vec, win_vec;
    logic [DATA_W-1:0]      win_word, rd_next;
    logic                   unused_wdata;

    assign unused_wdata = ^bus_wdata[13:5];

    pic_src_map #(.NUM_TMR(NUM_TMR), .NUM_EXT(NUM_EXT)) u_map (
        .slave    (slave_q),
        .tmr_req  (tmr_req),
        .ext_req  (ext_req),
        .slot_req (slot_req),
        .slot_act (slot_act)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_fields
        // Split each control word into mask and priority
        assign mask[i] = ctrl_q[i*CTRL_W + 3];
        assign prio_flat[i*PRIO_W +: PRIO_W] = ctrl_q[i*CTRL_W +: PRIO_W];
    end

    assign req_rise = slot_req & ~req_q;

    // Rank among slots already in service
    pic_arbiter #(.N(NSRC)) u_is_arb (
        .req       (insvc_q),
        .prio_flat (prio_flat),
        .found     (is_found),
        .idx       (is_idx),
        .best      (is_best)
    );

    // Eligibility: pending, unmasked, strictly above every in-service slot
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = pend_q[i] & ~mask[i] &
                      (~is_found | (prio_flat[i*PRIO_W +: PRIO_W] < is_best));
        end
    end

    // Winner among eligible slots
    pic_arbiter #(.N(NSRC)) u_pd_arb (
        .req       (elig),
        .prio_flat (prio_flat),
        .found     (pd_found),
        .idx       (pd_idx),
        .best      (pd_best)
    );

    assign win_vec  = VEC_W'(VEC_BASE) + VEC_W'(pd_idx);
    assign win_word = poll_word(pd_found, win_vec);

    assign ack_req   = (bus_rd && bus_addr == A_POLL) || int_ack;
    assign ack_fire  = ack_req && pd_found;
    assign eoi_wr    = bus_wr && bus_addr == A_EOI;
    assign eoi_nspec = bus_wdata[NSPEC_BIT];
    assign eoi_vec   = bus_wdata[VEC_W-1:0];

    // Per-slot set and clear masks for the in-service bits
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            ack_set[i] = ack_fire && pd_idx == IDX_W'(i);
            if (!eoi_wr)
                eoi_clr[i] = 1'b0;
            else if (eoi_nspec)
                eoi_clr[i] = is_found && is_idx == IDX_W'(i);
            else
                eoi_clr[i] = eoi_vec == VEC_W'(VEC_BASE + i);
        end
    end

    // Read mux for the registered read port
    always_comb begin
        rd_next = '0;
        case (bus_addr)
            A_CFG:   rd_next[SLAVE_BIT] = slave_q;
            A_POLL,
            A_PSTAT: rd_next = win_word;
            A_INSVC: rd_next[NSRC-1:0] = insvc_q;
            A_PEND:  rd_next[NSRC-1:0] = pend_q;
            default: begin
                for (int i = 0; i < NSRC; i++) begin
                    if (bus_addr == A_CTRL0 + 4'(i))
                        rd_next[CTRL_W-1:0] = ctrl_q[i*CTRL_W +: CTRL_W];
                end
            end
        endcase
    end

    // Configuration and control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave_q <= 1'b0;
            ctrl_q  <= {NSRC{4'hF}};
        end else if (bus_wr) begin
            if (bus_addr == A_CFG)
                slave_q <= bus_wdata[SLAVE_BIT];
            for (int i = 0; i < NSRC; i++) begin
                if (bus_addr == A_CTRL0 + 4'(i))
                    ctrl_q[i*CTRL_W +: CTRL_W] <= bus_wdata[CTRL_W-1:0];
            end
        end
    end

    // Request edge capture, pending and in-service tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            pend_q  <= '0;
            insvc_q <= '0;
        end else begin
            req_q   <= slot_req;
            pend_q  <= ((pend_q & ~ack_set) | req_rise) & slot_act;
            insvc_q <= ((insvc_q & ~eoi_clr) | ack_set) & slot_act;
        end
    end

    // Read data register, updated once per read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;
    assign cpu_irq   = pd_found & ~slave_q;
    assign up_req    = pd_found & slave_q;

    // R4
    poll_sets_is_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> ((insvc_q & $past(ack_set)) == $past(ack_set)));

    // R3
    peek_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_PSTAT && !int_ack && !bus_wr && req_rise == '0)
        |=> ($stable(insvc_q) && $stable(pend_q)));

    // R6
    nest_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_found && is_found) |-> (pd_best < is_best));

    // R8
    eoi_rank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && eoi_nspec && is_found && !ack_fire)
        |=> ($countones(insvc_q) + 1 == $countones($past(insvc_q))));

    // R10
    slave_ext_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_q && $past(slave_q)) |-> (pend_q[NSRC-1:NUM_TMR] == '0));

    // R11
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && $countones(elig) == 1 && req_rise == '0 && !bus_wr)
        |=> !(cpu_irq || up_req));
endmodule

// File: tb/prio_pic_bench.sv
`timescale 1ns/1ps
module prio_pic_bench;
    localparam int NT = 3;
    localparam int NE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0, int_ack = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [NT-1:0] tmr_req = '0;
    logic [NE-1:0] ext_req = '0;
    logic          cpu_irq, up_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_was = 1'b0;
    logic [15:0] mon_exp;
    string       mon_tag;

    always #2.5 clk = ~clk;

    prio_pic #(.NUM_TMR(NT), .NUM_EXT(NE), .VEC_BASE(8)) u_prio_pic (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_req(tmr_req), .ext_req(ext_req), .int_ack(int_ack),
        .cpu_irq(cpu_irq), .up_req(up_req)
    );

    // Monitor: compares read data against queued expectations
    always @(posedge clk) rd_was <= bus_rd;
    always @(negedge clk) begin
        if (rd_was) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: got %h expected none", bus_rdata);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                checks++;
                if (bus_rdata !== mon_exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", mon_tag, bus_rdata, mon_exp);
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [3:0] a, input logic [15:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_tmr(input int i);
        tmr_req[i] = 1'b1; @(negedge clk); tmr_req[i] = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_ext(input int i);
        ext_req[i] = 1'b1; @(negedge clk); ext_req[i] = 1'b0; @(negedge clk);
    endtask

    task automatic ack_pulse();
        int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_exp(4'd0, 16'h0000, "R1 config");
        rd_exp(4'd8, 16'h000F, "R1 ctrl0");
        rd_exp(4'd5, 16'h0000, "R1 insvc");
        rd_exp(4'd6, 16'h0000, "R1 pend");
        rd_exp(4'd4, 16'h0000, "R1 status");
        chk(cpu_irq, 1'b0, "R1 cpu_irq");
        chk(up_req, 1'b0, "R1 up_req");
        // R7 masked slot latches pending but is not eligible
        pulse_ext(0);
        rd_exp(4'd6, 16'h0008, "R7 pend masked");
        rd_exp(4'd4, 16'h0000, "R7 status masked");
        chk(cpu_irq, 1'b0, "R7 irq masked");
        wr_reg(4'd11, 16'h0005);
        rd_exp(4'd4, 16'h800B, "R7 R2 status unmasked");
        chk(cpu_irq, 1'b1, "R11 cpu_irq high");
        // R3 peek repeated, no side effect
        rd_exp(4'd4, 16'h800B, "R3 status again");
        rd_exp(4'd5, 16'h0000, "R3 insvc");
        rd_exp(4'd6, 16'h0008, "R3 pend");
        // R5 lower value wins
        wr_reg(4'd12, 16'h0002);
        pulse_ext(1);
        rd_exp(4'd4, 16'h800C, "R5 priority");
        // R4 acknowledge read
        rd_exp(4'd3, 16'h800C, "R4 poll");
        rd_exp(4'd5, 16'h0010, "R4 insvc");
        rd_exp(4'd6, 16'h0008, "R4 pend");
        chk(cpu_irq, 1'b0, "R11 irq after ack");
        rd_exp(4'd4, 16'h0000, "R6 lower rank blocked");
        // R8 specific end-of-service
        wr_reg(4'd2, 16'h000C);
        rd_exp(4'd5, 16'h0000, "R8 specific");
        rd_exp(4'd4, 16'h800B, "R8 status after");
        // R5 tie goes to lower index
        wr_reg(4'd11, 16'h0002);
        pulse_ext(1);
        rd_exp(4'd4, 16'h800B, "R5 tie");
        // R12 hardware acknowledge
        ack_pulse();
        rd_exp(4'd5, 16'h0008, "R12 insvc");
        rd_exp(4'd4, 16'h0000, "R6 equal rank blocked");
        rd_exp(4'd3, 16'h0000, "R4 poll empty");
        rd_exp(4'd5, 16'h0008, "R4 empty poll no change");
        // R8 ranked end-of-service
        wr_reg(4'd2, 16'h8000);
        rd_exp(4'd5, 16'h0000, "R8 nonspecific");
        rd_exp(4'd3, 16'h800C, "R4 poll second");
        wr_reg(4'd2, 16'h8000);
        rd_exp(4'd5, 16'h0000, "R8 nonspecific 2");
        // R13 held line pends once
        ext_req[0] = 1'b1;
        @(negedge clk);
        rd_exp(4'd3, 16'h800B, "R13 poll held");
        rd_exp(4'd6, 16'h0000, "R13 pend after ack");
        wr_reg(4'd2, 16'h8000);
        rd_exp(4'd4, 16'h0000, "R13 no repend");
        ext_req[0] = 1'b0;
        @(negedge clk);
        // R9 merged timers in stand-alone mode
        wr_reg(4'd8, 16'h0004);
        pulse_tmr(2);
        rd_exp(4'd4, 16'h8008, "R9 timer2 to slot0");
        rd_exp(4'd3, 16'h8008, "R9 poll");
        wr_reg(4'd2, 16'h0008);
        pulse_tmr(1);
        rd_exp(4'd6, 16'h0001, "R9 timer1 to slot0");
        rd_exp(4'd3, 16'h8008, "R9 poll 2");
        wr_reg(4'd2, 16'h0008);
        // R10 subordinate mode
        wr_reg(4'd0, 16'h4000);
        rd_exp(4'd0, 16'h4000, "R10 config");
        pulse_ext(0);
        rd_exp(4'd6, 16'h0000, "R10 ext ignored");
        wr_reg(4'd9, 16'h0003);
        pulse_tmr(1);
        rd_exp(4'd4, 16'h8009, "R10 own timer slot");
        chk(up_req, 1'b1, "R11 up_req high");
        chk(cpu_irq, 1'b0, "R11 cpu_irq low in sub");
        rd_exp(4'd3, 16'h8009, "R10 poll");
        chk(up_req, 1'b0, "R11 up_req after ack");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule